// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block watches five condition inputs of a serial channel, such as modem control lines and a break/abort detector. While it is armed, it compares the inputs each clock against a stored reference. If any bit differs, the block captures all five inputs in one snapshot, freezes, and raises an interrupt. While it is frozen, the status word shows the captured snapshot and any further input activity is ignored. The host re-arms the block by pulsing a clear command. The clear drops the interrupt and takes the inputs present at that edge as the new reference.

Bit 4 carries the break/abort indication by convention. The start of a break and the end of a break are both bit changes, so each one produces its own interrupt. The interrupt enable only masks the output. Capture and freezing go on while it is low.

The control is a three-state machine:
- SEED: entered on reset. It loads the reference and moves to ARMED.
- ARMED: on a clear it reloads the reference and stays in ARMED. Otherwise, on a change it captures and moves to FROZEN.
- FROZEN: on a clear it reloads the reference and returns to ARMED. Otherwise it stays in FROZEN.

Top module: `ext_status_latch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq_o` is 0.
- R2: In the armed state, a change of any single bit of `cond_i` at a clock edge sets `irq_o` to 1 after that edge, provided `irq_en_i` is 1.
- R3: On capture, `status_o` equals all five bits of `cond_i` as sampled at the capturing edge, including when several bits change at once.
- R4: Once captured, later changes of `cond_i` leave `status_o` and the pending interrupt unchanged until a clear.
- R5: A clear (`clr_cmd_i`=1 at an edge) drops `irq_o` after that edge and re-arms the block. `status_o` then follows the live inputs, and the inputs present at the clear become the reference, so they do not re-trigger.
- R6: A 0-to-1 change of bit 4 (break start) and a 1-to-0 change of bit 4 (break end) each produce a separate interrupt.
- R7: With `irq_en_i`=0, `irq_o` stays 0 but capture and freezing still occur. Raising `irq_en_i` while frozen shows the pending interrupt.
- R8: A clear in the armed state at the same edge as an input change wins. The change is absorbed into the reference and raises no interrupt.
- R9: The inputs present when reset is released are taken as the reference at the first edge, so nonzero inputs during reset raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 5 | Synchronized condition inputs; bit 4 is break/abort |
| irq_en_i | input | 1 | Interrupt output enable |
| clr_cmd_i | input | 1 | Clear/re-arm command strobe, one cycle |
| status_o | output | 5 | Snapshot when frozen, live inputs otherwise |
| irq_o | output | 1 | Interrupt, high while frozen and enabled |

## Verification
The main function is driven with a single low-bit change, a multi-bit change that also includes a break end, and an isolated break start followed by its end. Together these show that every bit triggers, that all five bits are captured together, and that both break edges interrupt. Bursts of changes while frozen separate a true freeze from a snapshot that keeps following the inputs. A clear that coincides with a change separates priority to the clear from priority to capture. Changes with the enable low, checked afterwards through the frozen status word, separate masking the output from suppressing the capture.

// File: rtl/esl_pkg.sv
package esl_pkg;
    typedef enum logic [1:0] {
        ESL_SEED   = 2'd0,
        ESL_ARMED  = 2'd1,
        ESL_FROZEN = 2'd2
    } esl_state_e;
endpackage

// File: rtl/esl_change_detect.sv
module esl_change_detect #(
    parameter int W = 5
) (
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] ref_i,
    output logic         changed_o
);
    logic [W-1:0] diff;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign diff[b] = live_i[b] ^ ref_i[b];
    end

    assign changed_o = |diff;
endmodule

// File: rtl/esl_snap_reg.sv
module esl_snap_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_ref_i,
    input  logic         capture_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] ref_o,
    output logic [W-1:0] snap_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_o  <= '0;
            snap_o <= '0;
        end else if (capture_i) begin
            snap_o <= live_i;
            ref_o  <= live_i;
        end else if (load_ref_i) begin
            ref_o  <= live_i;
        end
    end
endmodule

// File: rtl/esl_ctrl_fsm.sv
module esl_ctrl_fsm
    import esl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       changed_i,
    input  logic       clr_i,
    output esl_state_e state_o,
    output logic       load_ref_o,
    output logic       capture_o,
    output logic       frozen_o
);
    esl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ESL_SEED;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ESL_SEED:   state_d = ESL_ARMED;
            ESL_ARMED:  if (!clr_i && changed_i) state_d = ESL_FROZEN;
            ESL_FROZEN: if (clr_i) state_d = ESL_ARMED;
            default:    state_d = ESL_SEED;
        endcase
    end

    // Outputs
    always_comb begin
        load_ref_o = 1'b0;
        capture_o  = 1'b0;
        frozen_o   = 1'b0;
        unique case (state_q)
            ESL_SEED:   load_ref_o = 1'b1;
            ESL_ARMED: begin
                load_ref_o = clr_i;
                capture_o  = !clr_i && changed_i;
            end
            ESL_FROZEN: begin
                frozen_o   = 1'b1;
                load_ref_o = clr_i;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ext_status_latch.sv
module ext_status_latch
    import esl_pkg::*;
#(
    parameter int N_COND = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] cond_i,
    input  logic              irq_en_i,
    input  logic              clr_cmd_i,
    output logic [N_COND-1:0] status_o,
    output logic              irq_o
);
    logic              changed;
    logic              load_ref;
    logic              capture;
    logic              frozen;
    esl_state_e        state_q;
    logic [N_COND-1:0] ref_q;
    logic [N_COND-1:0] snap_q;

    esl_change_detect #(.W(N_COND)) u_det (
        .live_i    (cond_i),
        .ref_i     (ref_q),
        .changed_o (changed)
    );

    esl_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .changed_i  (changed),
        .clr_i      (clr_cmd_i),
        .state_o    (state_q),
        .load_ref_o (load_ref),
        .capture_o  (capture),
        .frozen_o   (frozen)
    );

    esl_snap_reg #(.W(N_COND)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_ref_i (load_ref),
        .capture_i  (capture),
        .live_i     (cond_i),
        .ref_o      (ref_q),
        .snap_o     (snap_q)
    );

    assign status_o = frozen ? snap_q : cond_i;
    assign irq_o    = frozen & irq_en_i;
endmodule

// File: rtl/esl_checker.sv
module esl_checker
    import esl_pkg::*;
#(
    parameter int N_COND = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_COND-1:0] cond_i,
    input logic              irq_en_i,
    input logic              clr_cmd_i,
    input logic [N_COND-1:0] status_o,
    input logic              irq_o,
    input esl_state_e        state_q,
    input logic [N_COND-1:0] ref_q
);
    // R1: no interrupt while seeding after reset
    a_r1_seed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ESL_SEED) |-> !irq_o);

    // R2, R3: a change while armed freezes with the sampled inputs
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ESL_ARMED && !clr_cmd_i && cond_i != ref_q)
        |=> (state_q == ESL_FROZEN && status_o == $past(cond_i)));

    // R4: the frozen snapshot holds until a clear
    a_r4_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ESL_FROZEN && !clr_cmd_i) |=> $stable(status_o));

    // R5: a clear drops the interrupt
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd_i |=> !irq_o);

    // R7: the enable masks the output
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);

    // R8: a clear in the armed state never leads to a frozen state
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ESL_ARMED && clr_cmd_i) |=> (state_q == ESL_ARMED));
endmodule

bind ext_status_latch esl_checker #(.N_COND(N_COND)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_i    (cond_i),
    .irq_en_i  (irq_en_i),
    .clr_cmd_i (clr_cmd_i),
    .status_o  (status_o),
    .irq_o     (irq_o),
    .state_q   (state_q),
    .ref_q     (ref_q)
);

// File: tb/ext_status_latch_bench.sv
module ext_status_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cond_i = 5'b00011;
    logic       irq_en_i = 1'b1;
    logic       clr_cmd_i = 1'b0;
    logic [4:0] status_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ext_status_latch u_ext_status_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .irq_en_i  (irq_en_i),
        .clr_cmd_i (clr_cmd_i),
        .status_o  (status_o),
        .irq_o     (irq_o)
    );

    // {clr, en, cond[4:0], exp_irq, exp_status[4:0]}
    localparam int NV = 22;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b1, 5'b00011, 1'b0, 5'b00011},  // steady, no change
        {1'b0, 1'b1, 5'b00111, 1'b1, 5'b00111},  // R2 single bit
        {1'b0, 1'b1, 5'b01000, 1'b1, 5'b00111},  // R4 frozen
        {1'b0, 1'b1, 5'b11111, 1'b1, 5'b00111},  // R4 frozen
        {1'b1, 1'b1, 5'b11111, 1'b0, 5'b11111},  // R5 clear
        {1'b0, 1'b1, 5'b11111, 1'b0, 5'b11111},  // R5 no re-trigger
        {1'b0, 1'b1, 5'b01110, 1'b1, 5'b01110},  // R3 multi-bit, R6 break end
        {1'b1, 1'b1, 5'b01110, 1'b0, 5'b01110},  // R5
        {1'b0, 1'b1, 5'b11110, 1'b1, 5'b11110},  // R6 break start
        {1'b1, 1'b1, 5'b11110, 1'b0, 5'b11110},  // R5
        {1'b0, 1'b1, 5'b01110, 1'b1, 5'b01110},  // R6 break end
        {1'b0, 1'b0, 5'b01110, 1'b0, 5'b01110},  // R7 mask
        {1'b0, 1'b1, 5'b01110, 1'b1, 5'b01110},  // R7 unmask
        {1'b1, 1'b0, 5'b01110, 1'b0, 5'b01110},  // R5
        {1'b0, 1'b0, 5'b01100, 1'b0, 5'b01100},  // R7 masked capture
        {1'b0, 1'b0, 5'b00000, 1'b0, 5'b01100},  // R7 capture proven frozen
        {1'b0, 1'b1, 5'b00000, 1'b1, 5'b01100},  // R7 pending shown
        {1'b1, 1'b1, 5'b00000, 1'b0, 5'b00000},  // R5
        {1'b1, 1'b1, 5'b10101, 1'b0, 5'b10101},  // R8 clear with change
        {1'b0, 1'b1, 5'b10101, 1'b0, 5'b10101},  // R8 absorbed
        {1'b1, 1'b1, 5'b00001, 1'b0, 5'b00001},  // R8
        {1'b0, 1'b1, 5'b00001, 1'b0, 5'b00001}   // R5
    };
    localparam int REQ [NV] = '{5, 2, 4, 4, 5, 5, 3, 5, 6, 5, 6, 7, 7, 5, 7, 7, 7, 5, 8, 8, 8, 5};

    task automatic check(input string req, input logic [4:0] st_exp, input logic irq_exp);
        checks++;
        if (status_o !== st_exp || irq_o !== irq_exp) begin
            errors++;
            $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
                     req, status_o, irq_o, st_exp, irq_exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 5'b00011, 1'b0);          // R1 in reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 5'b00011, 1'b0);          // R9 seed with nonzero inputs

        for (int i = 0; i < NV; i++) begin
            clr_cmd_i = VEC[i][12];
            irq_en_i  = VEC[i][11];
            cond_i    = VEC[i][10:6];
            @(negedge clk);
            check($sformatf("R%0d row %0d", REQ[i], i), VEC[i][4:0], VEC[i][5]);
        end
        clr_cmd_i = 1'b0;
        irq_en_i  = 1'b1;

        // Freeze, then reset mid-run with new inputs
        cond_i = 5'b00000;
        @(negedge clk);
        check("R2", 5'b00000, 1'b1);
        cond_i = 5'b11000;
        rst_n  = 1'b0;
        #1;
        check("R1", 5'b11000, 1'b0);          // R1 asynchronous clear
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 5'b11000, 1'b0);          // R9 reseed
        @(negedge clk);
        check("R9", 5'b11000, 1'b0);
        cond_i = 5'b11001;
        @(negedge clk);
        check("R2", 5'b11001, 1'b1);          // R2 lowest bit

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule